// File: doc/BRIEF.md
# NAND page fetch engine

This block serves a cache miss that must be filled from raw NAND flash. A cache controller hands it a page number. The engine holds that page address on the flash side and waits out the array access time. It then reads the page one byte per transfer slot. The 512 data bytes go onto a valid/ready fill stream, each tagged with its index. The 16 spare bytes that follow are kept off the stream.

While the spare bytes pass, the engine extracts the metadata that guides caching. This metadata is the page's cache priority class, a prefetch hint byte, and a marker for a page in a bad block. The engine presents all three to the cache controller together with the done pulse that closes the fill.

All timing comes from nanosecond parameters and a clock-period parameter. At the default 5 ns clock, the 10 us access time becomes 2000 cycles and the 50 ns byte slot becomes 10 cycles. The engine handles one page at a time and does not accept a new request until the current fill has finished.

Top module: `nand_page_fetch`

## Requirements
- R1: `reqReady` is high exactly while the engine is idle. A request is taken on a cycle with `reqValid` and `reqReady` both high. `flashPage` then holds the taken page number and does not change until the next request is taken.
- R2: The first data byte appears on `fillValid` exactly LAT_CYC + BYTE_CYC cycles after the request is taken. At the defaults this is 2010 cycles.
- R3: Data bytes arrive in column order with `fillIdx` running 0 to 511. Each `fillData` equals the flash byte at column `fillIdx`. When `fillReady` stays high, consecutive bytes are BYTE_CYC cycles apart.
- R4: While `fillValid` is high and `fillReady` is low, `fillValid`, `fillData` and `fillIdx` hold their values. No byte is lost or repeated, and the reading of later columns pauses.
- R5: The spare columns 512 to 527 never appear on the fill stream. Each page produces exactly 512 stream handshakes, and `fillValid` is low whenever the engine is idle.
- R6: `done` is high for exactly one cycle after column 527 has been read and the last data byte has been taken. With `fillReady` held high, this is LAT_CYC + 528*BYTE_CYC cycles after the request is taken (7280 at the defaults). `reqReady` rises in the cycle after `done`.
- R7: A `reqValid` raised while the engine is busy has no effect on `flashPage` or the stream. It is not queued, and no fill starts after `done` unless a new request is made.
- R8: `pagePrio` is decoded from bits [1:0] of spare byte 0 (column 512), and the upper bits of that byte are ignored. The raw values map as follows: 0 gives 0 (low), 1 gives 1 (mid), 2 gives 2 (high), and 3 gives 0 (low). `pagePrio` never shows 3, and it stays unchanged while the engine is idle.
- R9: `prefetchHint` equals spare byte 1 (column 513) of the last page fetched.
- R10: `badPage` is 1 when spare byte 5 (column 517) of the last page fetched is not 8'hFF, and 0 otherwise.
- R11: After reset, `reqReady` is 1, and `fillValid`, `done`, `pagePrio`, `prefetchHint` and `badPage` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Page fetch request |
| reqPage | input | 16 | Page number to fetch |
| reqReady | output | 1 | Engine idle, request can be taken |
| flashPage | output | 16 | Page address presented to the flash array |
| flashCol | output | 10 | Column (0 to 527) presented to the flash array |
| flashByte | input | 8 | Byte read back from the flash array at the addressed column |
| fillValid | output | 1 | Fill stream byte valid |
| fillReady | input | 1 | Fill stream sink ready |
| fillData | output | 8 | Fill stream data byte |
| fillIdx | output | 9 | Index of the byte within the page |
| done | output | 1 | One-cycle pulse closing a page fill |
| pagePrio | output | 2 | Decoded cache priority: 0 low, 1 mid, 2 high |
| prefetchHint | output | 8 | Prefetch hint byte from the spare area |
| badPage | output | 1 | Bad-block marker present in the spare area |

## Verification
The hardest case to reach is a stalled fill sink at the moment a new byte slot ends. In that case the column timer must freeze, and the held byte must survive while later columns wait. The stimulus reaches it by dropping `fillReady` in windows of 13 cycles, which is longer than a 10-cycle byte slot. Every data byte must still arrive once, in order and correct. A second hard case is a request raised in the middle of a fill. The stimulus raises `reqValid` with a different page 100 cycles into a fetch, then checks that the streamed bytes still belong to the first page and that nothing starts after `done`.

// File: rtl/nand_fetch_pkg.sv
`timescale 1ns/1ps
package nand_fetch_pkg;

  typedef enum logic [1:0] {
    PRIO_LOW  = 2'd0,
    PRIO_MID  = 2'd1,
    PRIO_HIGH = 2'd2
  } pagePrio_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_XFER,
    ST_FINISH
  } fetchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadPage;   // latch request page
    logic startXfer;  // access latency over, rewind column
    logic slotEnd;    // byte slot complete, sample flash byte
  } fetchStrobe_t;

  function automatic pagePrio_e decodePrio(input logic [1:0] raw);
    case (raw)
      2'd1:    return PRIO_MID;
      2'd2:    return PRIO_HIGH;
      default: return PRIO_LOW;   // 0 and reserved 3
    endcase
  endfunction

endpackage

// File: rtl/nand_fetch_ctrl.sv
`timescale 1ns/1ps
module nand_fetch_ctrl
  import nand_fetch_pkg::*;
#(
  parameter int LAT_CYC  = 2000,
  parameter int BYTE_CYC = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         colIsData,
  input  logic         colIsLast,
  input  logic         fillPending,
  input  logic         fillReady,
  output fetchStrobe_t strobe,
  output logic         reqReady,
  output logic         done
);

  localparam int MAXC  = (LAT_CYC > BYTE_CYC) ? LAT_CYC : BYTE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] LAT_LOAD  = CNT_W'(LAT_CYC - 1);
  localparam logic [CNT_W-1:0] BYTE_LOAD = CNT_W'(BYTE_CYC - 1);

  fetchState_e state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic sinkStall;

  // a data slot may not end while the previous byte still waits for the sink
  assign sinkStall = colIsData && fillPending && !fillReady;

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextCnt   = cnt;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadPage = 1'b1;
          nextState       = ST_WAIT;
          nextCnt         = LAT_LOAD;
        end
      end
      ST_WAIT: begin
        if (cnt == '0) begin
          strobe.startXfer = 1'b1;
          nextState        = ST_XFER;
          nextCnt          = BYTE_LOAD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_XFER: begin
        if (cnt != '0) begin
          nextCnt = cnt - 1'b1;
        end else if (!sinkStall) begin
          strobe.slotEnd = 1'b1;
          if (colIsLast) nextState = ST_FINISH;
          else           nextCnt   = BYTE_LOAD;
        end
      end
      ST_FINISH: begin
        if (!fillPending) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign done     = (state == ST_FINISH) && !fillPending;

endmodule

// File: rtl/nand_fetch_dp.sv
`timescale 1ns/1ps
module nand_fetch_dp
  import nand_fetch_pkg::*;
#(
  parameter int PAGE_W      = 16,
  parameter int DATA_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int PRIO_SPARE  = 0,
  parameter int HINT_SPARE  = 1,
  parameter int BAD_SPARE   = 5,
  localparam int TOTAL      = DATA_BYTES + SPARE_BYTES,
  localparam int COL_W      = $clog2(TOTAL),
  localparam int IDX_W      = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  fetchStrobe_t      strobe,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic [7:0]        flashByte,
  input  logic              fillReady,
  output logic [PAGE_W-1:0] flashPage,
  output logic [COL_W-1:0]  flashCol,
  output logic              fillValid,
  output logic [7:0]        fillData,
  output logic [IDX_W-1:0]  fillIdx,
  output logic              colIsData,
  output logic              colIsLast,
  output pagePrio_e         pagePrio,
  output logic [7:0]        prefetchHint,
  output logic              badPage
);

  localparam logic [COL_W-1:0] DATA_END = COL_W'(DATA_BYTES);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(TOTAL - 1);
  localparam logic [COL_W-1:0] PRIO_COL = COL_W'(DATA_BYTES + PRIO_SPARE);
  localparam logic [COL_W-1:0] HINT_COL = COL_W'(DATA_BYTES + HINT_SPARE);
  localparam logic [COL_W-1:0] BAD_COL  = COL_W'(DATA_BYTES + BAD_SPARE);

  logic [COL_W-1:0] col;

  assign flashCol  = col;
  assign colIsData = (col < DATA_END);
  assign colIsLast = (col == LAST_COL);

  // page address register
  always_ff @(posedge clk) begin
    if (!rst_n)               flashPage <= '0;
    else if (strobe.loadPage) flashPage <= reqPage;
  end

  // column pointer
  always_ff @(posedge clk) begin
    if (!rst_n)                             col <= '0;
    else if (strobe.startXfer)              col <= '0;
    else if (strobe.slotEnd && !colIsLast)  col <= col + 1'b1;
  end

  // one-entry holding stage toward the fill port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fillValid <= 1'b0;
      fillData  <= '0;
      fillIdx   <= '0;
    end else if (strobe.slotEnd && colIsData) begin
      fillValid <= 1'b1;
      fillData  <= flashByte;
      fillIdx   <= col[IDX_W-1:0];
    end else if (fillReady) begin
      fillValid <= 1'b0;
    end
  end

  // spare-area field capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pagePrio     <= PRIO_LOW;
      prefetchHint <= '0;
      badPage      <= 1'b0;
    end else if (strobe.slotEnd) begin
      if (col == PRIO_COL) pagePrio     <= decodePrio(flashByte[1:0]);
      if (col == HINT_COL) prefetchHint <= flashByte;
      if (col == BAD_COL)  badPage      <= (flashByte != 8'hFF);
    end
  end

endmodule

// File: rtl/nand_page_fetch.sv
`timescale 1ns/1ps
module nand_page_fetch
  import nand_fetch_pkg::*;
#(
  parameter int PAGE_W      = 16,
  parameter int DATA_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int CLK_PS      = 5000,
  parameter int ACCESS_NS   = 10000,
  parameter int BYTE_NS     = 50,
  parameter int PRIO_SPARE  = 0,
  parameter int HINT_SPARE  = 1,
  parameter int BAD_SPARE   = 5,
  localparam int COL_W      = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int IDX_W      = $clog2(DATA_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [PAGE_W-1:0] reqPage,
  output logic              reqReady,
  output logic [PAGE_W-1:0] flashPage,
  output logic [COL_W-1:0]  flashCol,
  input  logic [7:0]        flashByte,
  output logic              fillValid,
  input  logic              fillReady,
  output logic [7:0]        fillData,
  output logic [IDX_W-1:0]  fillIdx,
  output logic              done,
  output logic [1:0]        pagePrio,
  output logic [7:0]        prefetchHint,
  output logic              badPage
);

  localparam int LAT_CYC  = (ACCESS_NS * 1000) / CLK_PS;
  localparam int BYTE_CYC = (BYTE_NS * 1000) / CLK_PS;

  fetchStrobe_t strobe;
  logic colIsData, colIsLast;
  pagePrio_e prioDec;

  nand_fetch_ctrl #(
    .LAT_CYC (LAT_CYC),
    .BYTE_CYC(BYTE_CYC)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .colIsData  (colIsData),
    .colIsLast  (colIsLast),
    .fillPending(fillValid),
    .fillReady  (fillReady),
    .strobe     (strobe),
    .reqReady   (reqReady),
    .done       (done)
  );

  nand_fetch_dp #(
    .PAGE_W     (PAGE_W),
    .DATA_BYTES (DATA_BYTES),
    .SPARE_BYTES(SPARE_BYTES),
    .PRIO_SPARE (PRIO_SPARE),
    .HINT_SPARE (HINT_SPARE),
    .BAD_SPARE  (BAD_SPARE)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .reqPage     (reqPage),
    .flashByte   (flashByte),
    .fillReady   (fillReady),
    .flashPage   (flashPage),
    .flashCol    (flashCol),
    .fillValid   (fillValid),
    .fillData    (fillData),
    .fillIdx     (fillIdx),
    .colIsData   (colIsData),
    .colIsLast   (colIsLast),
    .pagePrio    (prioDec),
    .prefetchHint(prefetchHint),
    .badPage     (badPage)
  );

  assign pagePrio = prioDec;

endmodule

// File: rtl/nand_page_fetch_chk.sv
`timescale 1ns/1ps
module nand_page_fetch_chk #(
  parameter int PAGE_W     = 16,
  parameter int DATA_BYTES = 512,
  localparam int IDX_W     = $clog2(DATA_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic [PAGE_W-1:0] flashPage,
  input logic              fillValid,
  input logic              fillReady,
  input logic [7:0]        fillData,
  input logic [IDX_W-1:0]  fillIdx,
  input logic              done,
  input logic [1:0]        pagePrio
);

  // running count of stream handshakes within the current page
  logic [IDX_W-1:0] expIdx;
  always_ff @(posedge clk) begin
    if (!rst_n)                      expIdx <= '0;
    else if (reqValid && reqReady)   expIdx <= '0;
    else if (fillValid && fillReady) expIdx <= expIdx + 1'b1;
  end

  a_r1_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !reqReady |=> $stable(flashPage));

  a_r3_index_order: assert property (@(posedge clk) disable iff (!rst_n)
    fillValid |-> fillIdx == expIdx);

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (fillValid && !fillReady) |=> fillValid && $stable(fillData) && $stable(fillIdx));

  a_r5_no_fill_idle: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !fillValid);

  a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && reqReady);

  a_r8_prio_legal: assert property (@(posedge clk) disable iff (!rst_n)
    pagePrio != 2'd3);

  a_r8_prio_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (reqReady && !reqValid) |=> $stable(pagePrio));

endmodule

bind nand_page_fetch nand_page_fetch_chk #(
  .PAGE_W    (PAGE_W),
  .DATA_BYTES(DATA_BYTES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .flashPage(flashPage),
  .fillValid(fillValid),
  .fillReady(fillReady),
  .fillData (fillData),
  .fillIdx  (fillIdx),
  .done     (done),
  .pagePrio (pagePrio)
);

// File: tb/nand_page_fetch_test.sv
`timescale 1ns/1ps
module nand_page_fetch_test;

  localparam int LAT = (10000 * 1000) / 5000;
  localparam int BYT = (50 * 1000) / 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqPage = '0;
  logic        reqReady;
  logic [15:0] flashPage;
  logic [9:0]  flashCol;
  logic [7:0]  flashByte;
  logic        fillValid;
  logic        fillReady = 1'b1;
  logic [7:0]  fillData;
  logic [8:0]  fillIdx;
  logic        done;
  logic [1:0]  pagePrio;
  logic [7:0]  prefetchHint;
  logic        badPage;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nand_page_fetch uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqPage(reqPage),
    .reqReady(reqReady), .flashPage(flashPage), .flashCol(flashCol),
    .flashByte(flashByte), .fillValid(fillValid), .fillReady(fillReady),
    .fillData(fillData), .fillIdx(fillIdx), .done(done), .pagePrio(pagePrio),
    .prefetchHint(prefetchHint), .badPage(badPage)
  );

  // behavioural flash array
  logic [7:0] prioCfg [0:15];
  logic [7:0] hintCfg [0:15];
  logic [7:0] badCfg  [0:15];

  function automatic logic [7:0] expByte(input logic [15:0] pg, input logic [8:0] idx);
    return pg[7:0] ^ idx[7:0] ^ {idx[8], 7'h35};
  endfunction

  logic [9:0] sOff;
  always_comb begin
    sOff = flashCol - 10'd512;
    if (flashCol < 10'd512)  flashByte = expByte(flashPage, flashCol[8:0]);
    else if (sOff == 10'd0)  flashByte = prioCfg[flashPage[3:0]];
    else if (sOff == 10'd1)  flashByte = hintCfg[flashPage[3:0]];
    else if (sOff == 10'd5)  flashByte = badCfg[flashPage[3:0]];
    else                     flashByte = 8'hC3;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // results of the last page run
  int latFirst, latSecond, latDone, nBytes, nBad, leak, doneGone;

  // mode 0: sink always ready; 1: sink stalls in 13-cycle windows; 2: request while busy
  task automatic runPage(input logic [15:0] pg, input int mode);
    int k;
    @(negedge clk);
    fillReady = 1'b1;
    reqValid  = 1'b1;
    reqPage   = pg;
    while (!reqReady) @(negedge clk);
    @(posedge clk);
    #1 reqValid = 1'b0;
    k = 0; nBytes = 0; nBad = 0; leak = 0;
    latFirst = -1; latSecond = -1; latDone = -1;
    while (latDone < 0 && k < 40000) begin
      @(negedge clk);
      fillReady = (mode == 1) ? (((k / 13) % 3) != 0) : 1'b1;
      if (mode == 2) begin
        if (k >= 100 && k < 110) begin
          reqValid = 1'b1;
          reqPage  = pg + 16'd1;
          if (reqReady) leak++;
        end else begin
          reqValid = 1'b0;
        end
      end
      if (fillValid) begin
        if (latFirst < 0) latFirst = k;
        else if (latSecond < 0 && nBytes == 1) latSecond = k;
        if (fillReady) begin
          if (fillIdx != nBytes[8:0] || fillData != expByte(pg, nBytes[8:0])) nBad++;
          nBytes++;
        end
      end
      if (done) latDone = k;
      k++;
    end
    reqValid = 1'b0;
    @(negedge clk);
    doneGone = (!done && reqReady) ? 1 : 0;
  endtask

  task automatic t_reset();
    check(reqReady == 1'b1, "R11 reqReady after reset", reqReady, 1);
    check(fillValid == 1'b0, "R11 fillValid after reset", fillValid, 0);
    check(done == 1'b0, "R11 done after reset", done, 0);
    check(pagePrio == 2'd0, "R11 pagePrio after reset", pagePrio, 0);
    check(prefetchHint == 8'd0, "R11 prefetchHint after reset", prefetchHint, 0);
    check(badPage == 1'b0, "R11 badPage after reset", badPage, 0);
  endtask

  task automatic t_basic();
    runPage(16'd3, 0);
    check(flashPage == 16'd3, "R1 flashPage holds request", flashPage, 3);
    check(latFirst == LAT + BYT, "R2 first byte latency", latFirst, LAT + BYT);
    check(latSecond == LAT + 2 * BYT, "R3 byte spacing", latSecond, LAT + 2 * BYT);
    check(nBad == 0, "R3 data and index mismatches", nBad, 0);
    check(nBytes == 512, "R5 handshakes per page", nBytes, 512);
    check(latDone == LAT + 528 * BYT, "R6 done latency", latDone, LAT + 528 * BYT);
    check(doneGone == 1, "R6 done single cycle then ready", doneGone, 1);
    check(pagePrio == 2'd2, "R8 raw FE gives high", pagePrio, 2);
    check(prefetchHint == 8'h47, "R9 prefetch hint", prefetchHint, 8'h47);
    check(badPage == 1'b0, "R10 marker FF is good", badPage, 0);
  endtask

  task automatic t_prio();
    runPage(16'd4, 0);
    check(pagePrio == 2'd0, "R8 raw 0 gives low", pagePrio, 0);
    check(prefetchHint == 8'h00, "R9 hint zero", prefetchHint, 0);
    runPage(16'd5, 0);
    check(pagePrio == 2'd1, "R8 raw 7D gives mid", pagePrio, 1);
    check(prefetchHint == 8'hA9, "R9 hint A9", prefetchHint, 8'hA9);
    runPage(16'd6, 0);
    check(pagePrio == 2'd0, "R8 raw 3 gives low", pagePrio, 0);
    check(badPage == 1'b1, "R10 marker 00 is bad", badPage, 1);
    check(nBad == 0, "R3 data on page 6", nBad, 0);
  endtask

  task automatic t_backpressure();
    runPage(16'd7, 1);
    check(nBad == 0, "R4 data under stalls", nBad, 0);
    check(nBytes == 512, "R4 R5 byte count under stalls", nBytes, 512);
    check(latDone > LAT + 528 * BYT, "R4 stalls stretch the fill", latDone, LAT + 528 * BYT);
    check(pagePrio == 2'd1, "R8 prio after stalled fill", pagePrio, 1);
  endtask

  task automatic t_busy();
    int spurious;
    runPage(16'd8, 2);
    check(leak == 0, "R7 reqReady low while busy", leak, 0);
    check(nBad == 0, "R7 stream stays on first page", nBad, 0);
    check(flashPage == 16'd8, "R7 flashPage unchanged", flashPage, 8);
    spurious = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (fillValid || !reqReady || done) spurious++;
    end
    check(spurious == 0, "R7 no queued fetch", spurious, 0);
    check(pagePrio == 2'd2 && prefetchHint == 8'h11, "R8 R9 outputs hold while idle",
          {pagePrio, prefetchHint}, {2'd2, 8'h11});
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin
      prioCfg[i] = 8'h00;
      hintCfg[i] = 8'h00;
      badCfg[i]  = 8'hFF;
    end
    prioCfg[3] = 8'hFE; hintCfg[3] = 8'h47;
    prioCfg[5] = 8'h7D; hintCfg[5] = 8'hA9;
    prioCfg[6] = 8'h03; badCfg[6]  = 8'h00;
    prioCfg[7] = 8'h01;
    prioCfg[8] = 8'h02; hintCfg[8] = 8'h11;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_prio();
    t_backpressure();
    t_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule